// File: doc/BRIEF.md
# Key-Sense and Wakeup Interrupt Combiner

This block folds sixteen active-low key-sense inputs and eight active-low wakeup-event inputs into two shared external interrupt request lines. Each shared line also takes one dedicated active-low external pin. Line A gathers keys 7..0 and its dedicated pin. Line B gathers keys 15..8, wakeups 7..0 and its own dedicated pin. Every key and wakeup input has a mask bit. A set mask bit removes that input from its line. The unmasked inputs of a line are ANDed active-low, so any enabled input that goes low pulls the combined line low.

Each line has a sense select (low level or falling edge), a latched request flag and an enable bit. The flag latches whenever the sense condition holds, whatever the enable says. The request sent on to the processor is the flag gated by the enable. Software clears a flag by writing 0 to it, but only after it has read that flag as 1.

Each flag is held by a three-state machine:
- `FL_IDLE`: the flag reads 0.
- `FL_PEND`: the flag reads 1 and has not been read yet.
- `FL_SEEN`: the flag reads 1 and software has read it as 1.

The transitions are:
- IDLE→PEND when the sense condition holds (*detect*).
- PEND→SEEN on a read of the flag register (*observe*).
- SEEN→IDLE on a write of 0 to that bit when the condition does not hold (*clear*).
- SEEN→PEND on a write of 0 to that bit when the condition still holds (*re-arm*).
- Every other case keeps the present state.

Top module: `kswu_irq_combiner`

## Requirements
- R1: After reset, all three mask registers read 0xFF, the control register reads 0x00, the flag register reads 0x00, and `irq_req_o` is 0.
- R2: In low-level mode, an unmasked key input 7..0 held low sets the line A flag (flag register bit 0) within two rising clock edges.
- R3: A mask bit of 1 removes its input. A key held low under a set mask bit leaves the flag at 0.
- R4: Keys 15..8 and wakeups 7..0, when unmasked, each set the line B flag (flag register bit 1).
- R5: The line B dedicated pin is accepted only when all sixteen mask bits (key mask high and wakeup mask) are 1. Otherwise it has no effect on the line B flag.
- R6: The line A dedicated pin is accepted only while key mask bit 6 (address 0, bit 6) is 0.
- R7: A flag sets whether or not its enable is set. `irq_req_o[0]` and `irq_req_o[1]` equal the line A and line B flags gated by control bits 2 and 3.
- R8: With the edge-mode bit set (control bit 0 for line A, bit 1 for line B), only a high-to-low transition of the combined line sets the flag. A low level that persists does not set the flag again after a clear, and a rising edge never sets it.
- R9: Writing 0 to a flag bit clears it only if that flag was read as 1 before. A write of 0 with no prior read is ignored, and writing 1 never changes a flag.
- R10: In low-level mode, a flag cleared while the combined line is still low is set again.
- R11: Register map, 3-bit address:
  - 0: key mask 7..0
  - 1: key mask 15..8
  - 2: wakeup mask 7..0
  - 3: control (bits 1:0 edge mode for B:A, bits 3:2 enable for B:A)
  - 4: flags (bit 1 line B, bit 0 line A)
  
  Mask and control registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_n_i | input | 16 | Key-sense inputs, active low |
| wake_n_i | input | 8 | Wakeup-event inputs, active low |
| ext_a_n_i | input | 1 | Dedicated line A pin, active low |
| ext_b_n_i | input | 1 | Dedicated line B pin, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (marks flags as observed) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_req_o | output | 2 | Gated requests, bit 0 line A, bit 1 line B |

## Verification
An input change applied between edges is registered into the combined-line copy at the next rising edge. The flag machine moves on the edge after that, so a flag is due after the second rising edge. A mask or control write takes effect at its own edge and so adds one edge to that path. `irq_req_o` and `rdata_o` follow the flag state with no further register. The bench therefore lets three rising edges pass after every input or mask change. It applies reads and expected items on the falling edge and samples in the low phase. A flag-clear write is checked only once the corresponding input has been released and has settled.

// File: rtl/kswu_pkg.sv
package kswu_pkg;

    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_PEND = 2'd1,
        FL_SEEN = 2'd2
    } flag_state_e;

    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] ADDR_KMASK_LO = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_KMASK_HI = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_WMASK    = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_CTRL     = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_FLAGS    = 3'd4;

    localparam int N_LINES = 2;

endpackage

// File: rtl/kswu_group_merge.sv
module kswu_group_merge #(
    parameter int N_IN = 8
) (
    input  logic [N_IN-1:0] sense_n_i,
    input  logic [N_IN-1:0] mask_i,
    input  logic            pin_n_i,
    input  logic            pin_gate_i,
    output logic            comb_n_o
);
    logic inputs_high;
    logic pin_high;

    always_comb begin
        inputs_high = &(sense_n_i | mask_i);
        pin_high    = pin_n_i | ~pin_gate_i;
        comb_n_o    = inputs_high & pin_high;
    end

endmodule

// File: rtl/kswu_line_ctrl.sv
module kswu_line_ctrl
    import kswu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic comb_n_i,
    input  logic edge_mode_i,
    input  logic read_i,
    input  logic clr_i,
    output logic flag_o
);
    logic        comb_q;
    logic        comb_qq;
    logic        cond;
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comb_q  <= 1'b1;
            comb_qq <= 1'b1;
        end else begin
            comb_q  <= comb_n_i;
            comb_qq <= comb_q;
        end
    end

    always_comb begin
        if (edge_mode_i) cond = comb_qq & ~comb_q;
        else             cond = ~comb_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: if (cond)   state_d = FL_PEND;
            FL_PEND: if (read_i) state_d = FL_SEEN;
            FL_SEEN: if (clr_i)  state_d = cond ? FL_PEND : FL_IDLE;
            default:             state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q != FL_IDLE);
    end

    // R2
    rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(!comb_q));

    // R9
    fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(clr_i && state_q == FL_SEEN));

endmodule

// File: rtl/kswu_reg_port.sv
module kswu_reg_port
    import kswu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [REG_AW-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [N_LINES-1:0]  flags_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [2*DATA_W-1:0] kmask_o,
    output logic [DATA_W-1:0]   wmask_o,
    output logic [N_LINES-1:0]  edge_mode_o,
    output logic [N_LINES-1:0]  enable_o,
    output logic [N_LINES-1:0]  flag_rd_o,
    output logic [N_LINES-1:0]  flag_clr_o
);
    localparam int CTRL_W = 2 * N_LINES;

    logic [DATA_W-1:0] kmask_lo_q;
    logic [DATA_W-1:0] kmask_hi_q;
    logic [DATA_W-1:0] wmask_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              flags_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kmask_lo_q <= '1;
            kmask_hi_q <= '1;
            wmask_q    <= '1;
            ctrl_q     <= '0;
        end else if (wr_en_i) begin
            unique case (addr_i)
                ADDR_KMASK_LO: kmask_lo_q <= wdata_i;
                ADDR_KMASK_HI: kmask_hi_q <= wdata_i;
                ADDR_WMASK:    wmask_q    <= wdata_i;
                ADDR_CTRL:     ctrl_q     <= wdata_i[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        flags_sel   = (addr_i == ADDR_FLAGS);
        kmask_o     = {kmask_hi_q, kmask_lo_q};
        wmask_o     = wmask_q;
        edge_mode_o = ctrl_q[N_LINES-1:0];
        enable_o    = ctrl_q[CTRL_W-1:N_LINES];
        flag_rd_o   = {N_LINES{rd_en_i & flags_sel}};
        flag_clr_o  = {N_LINES{wr_en_i & flags_sel}} & ~wdata_i[N_LINES-1:0];
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_KMASK_LO: rdata_o = kmask_lo_q;
            ADDR_KMASK_HI: rdata_o = kmask_hi_q;
            ADDR_WMASK:    rdata_o = wmask_q;
            ADDR_CTRL:     rdata_o[CTRL_W-1:0] = ctrl_q;
            ADDR_FLAGS:    rdata_o[N_LINES-1:0] = flags_i;
            default:       rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/kswu_irq_combiner.sv
module kswu_irq_combiner
    import kswu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*DATA_W-1:0] key_n_i,
    input  logic [DATA_W-1:0]   wake_n_i,
    input  logic                ext_a_n_i,
    input  logic                ext_b_n_i,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [REG_AW-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [N_LINES-1:0]  irq_req_o
);
    localparam int KEY_N  = 2 * DATA_W;
    localparam int B_N    = DATA_W + DATA_W;
    localparam int A_GATE = 6;

    logic [KEY_N-1:0]   kmask;
    logic [DATA_W-1:0]  wmask;
    logic [N_LINES-1:0] edge_mode;
    logic [N_LINES-1:0] enable;
    logic [N_LINES-1:0] flag_rd;
    logic [N_LINES-1:0] flag_clr;
    logic [N_LINES-1:0] flags;
    logic [N_LINES-1:0] comb_n;
    logic [B_N-1:0]     b_sense_n;
    logic [B_N-1:0]     b_mask;
    logic               b_all_masked;

    kswu_reg_port #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .rd_en_i     (rd_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .flags_i     (flags),
        .rdata_o     (rdata_o),
        .kmask_o     (kmask),
        .wmask_o     (wmask),
        .edge_mode_o (edge_mode),
        .enable_o    (enable),
        .flag_rd_o   (flag_rd),
        .flag_clr_o  (flag_clr)
    );

    always_comb begin
        b_sense_n    = {key_n_i[KEY_N-1:DATA_W], wake_n_i};
        b_mask       = {kmask[KEY_N-1:DATA_W], wmask};
        b_all_masked = &b_mask;
    end

    kswu_group_merge #(.N_IN(DATA_W)) u_merge_a (
        .sense_n_i  (key_n_i[DATA_W-1:0]),
        .mask_i     (kmask[DATA_W-1:0]),
        .pin_n_i    (ext_a_n_i),
        .pin_gate_i (~kmask[A_GATE]),
        .comb_n_o   (comb_n[0])
    );

    kswu_group_merge #(.N_IN(B_N)) u_merge_b (
        .sense_n_i  (b_sense_n),
        .mask_i     (b_mask),
        .pin_n_i    (ext_b_n_i),
        .pin_gate_i (b_all_masked),
        .comb_n_o   (comb_n[1])
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        kswu_line_ctrl u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .comb_n_i    (comb_n[g]),
            .edge_mode_i (edge_mode[g]),
            .read_i      (flag_rd[g]),
            .clr_i       (flag_clr[g]),
            .flag_o      (flags[g])
        );
    end

    always_comb begin
        irq_req_o = flags & enable;
    end

    // R3
    all_masked_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&kmask[DATA_W-1:0]) |-> comb_n[0]);

    // R5
    ext_b_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_all_masked && (&(b_sense_n | b_mask))) |-> comb_n[1]);

    // R6
    ext_a_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kmask[A_GATE] && (&(key_n_i[DATA_W-1:0] | kmask[DATA_W-1:0]))) |-> comb_n[0]);

endmodule

// File: tb/kswu_irq_combiner_bench.sv
module kswu_irq_combiner_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] key_n = '1;
    logic [7:0]  wake_n = '1;
    logic        ext_a_n = 1'b1;
    logic        ext_b_n = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [1:0]  irq;

    typedef struct {
        bit         is_irq;
        logic [2:0] addr;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t expq[$];
    event sample_ev;
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    kswu_irq_combiner u_kswu_irq_combiner (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_n_i   (key_n),
        .wake_n_i  (wake_n),
        .ext_a_n_i (ext_a_n),
        .ext_b_n_i (ext_b_n),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .irq_req_o (irq)
    );

    initial begin
        forever begin
            @(sample_ev);
            if (expq.size() > 0) begin
                exp_t it;
                logic [7:0] act;
                it  = expq.pop_front();
                act = it.is_irq ? {6'b0, irq} : rdata;
                vectors++;
                if (act !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s: %s addr %0d actual %02h expected %02h",
                             it.tag, it.is_irq ? "irq" : "reg", it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        expq.push_back(it);
        #2 -> sample_ev;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic irq_check(input logic [1:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.addr = '0; it.exp = {6'b0, e}; it.tag = tag;
        expq.push_back(it);
        #2 -> sample_ev;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_check(3'd0, 8'hFF, "R1 kmask lo");
        rd_check(3'd1, 8'hFF, "R1 kmask hi");
        rd_check(3'd2, 8'hFF, "R1 wmask");
        rd_check(3'd3, 8'h00, "R1 ctrl");
        rd_check(3'd4, 8'h00, "R1 flags");
        irq_check(2'b00, "R1 irq");

        // R3 masked key ignored
        @(negedge clk) key_n[3] = 1'b0;
        settle();
        rd_check(3'd4, 8'h00, "R3 masked key");
        @(negedge clk) key_n[3] = 1'b1;
        settle();

        // R2 / R7 unmasked key sets flag regardless of enable
        wr(3'd0, 8'hF7);
        rd_check(3'd0, 8'hF7, "R11 kmask lo readback");
        @(negedge clk) key_n[3] = 1'b0;
        settle();
        irq_check(2'b00, "R7 flag without enable");
        wr(3'd3, 8'h04);
        irq_check(2'b01, "R2 flag set, R7 gated request");
        @(negedge clk) key_n[3] = 1'b1;
        settle();

        // R9 clear protocol
        wr(3'd4, 8'h00);
        irq_check(2'b01, "R9 clear without read ignored");
        rd_check(3'd4, 8'h01, "R9 flag reads 1");
        wr(3'd4, 8'h01);
        irq_check(2'b01, "R9 writing 1 keeps flag");
        wr(3'd4, 8'h00);
        irq_check(2'b00, "R9 cleared request");
        rd_check(3'd4, 8'h00, "R9 cleared flag");

        // R10 level persists
        @(negedge clk) key_n[3] = 1'b0;
        settle();
        rd_check(3'd4, 8'h01, "R10 flag set");
        wr(3'd4, 8'h00);
        settle();
        irq_check(2'b01, "R10 re-set while low");
        @(negedge clk) key_n[3] = 1'b1;
        settle();
        rd_check(3'd4, 8'h01, "R10 still pending");
        wr(3'd4, 8'h00);
        rd_check(3'd4, 8'h00, "R10 cleared after release");

        // R8 edge mode
        wr(3'd3, 8'h05);
        rd_check(3'd3, 8'h05, "R11 ctrl readback");
        @(negedge clk) key_n[3] = 1'b0;
        settle();
        rd_check(3'd4, 8'h01, "R8 falling edge sets");
        wr(3'd4, 8'h00);
        settle();
        rd_check(3'd4, 8'h00, "R8 held low no re-set");
        @(negedge clk) key_n[3] = 1'b1;
        settle();
        rd_check(3'd4, 8'h00, "R8 rising edge no set");
        @(negedge clk) key_n[3] = 1'b0;
        settle();
        rd_check(3'd4, 8'h01, "R8 second falling edge");
        @(negedge clk) key_n[3] = 1'b1;
        settle();
        wr(3'd4, 8'h00);
        rd_check(3'd4, 8'h00, "R8 cleared");

        // R6 dedicated line A pin
        wr(3'd3, 8'h00);
        wr(3'd0, 8'hFF);
        @(negedge clk) ext_a_n = 1'b0;
        settle();
        rd_check(3'd4, 8'h00, "R6 pin gated by mask bit 6");
        wr(3'd0, 8'hBF);
        settle();
        rd_check(3'd4, 8'h01, "R6 pin accepted");
        @(negedge clk) ext_a_n = 1'b1;
        settle();
        wr(3'd4, 8'h00);
        rd_check(3'd4, 8'h00, "R6 cleared");
        wr(3'd0, 8'hFF);

        // R4 line B sources
        wr(3'd1, 8'hFE);
        @(negedge clk) key_n[8] = 1'b0;
        settle();
        rd_check(3'd4, 8'h02, "R4 key 8 on line B");
        @(negedge clk) key_n[8] = 1'b1;
        settle();
        wr(3'd4, 8'h00);
        rd_check(3'd4, 8'h00, "R4 line B cleared");
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'h7F);
        rd_check(3'd2, 8'h7F, "R11 wmask readback");
        @(negedge clk) wake_n[7] = 1'b0;
        settle();
        rd_check(3'd4, 8'h02, "R4 wake 7 on line B");
        @(negedge clk) wake_n[7] = 1'b1;
        settle();
        wr(3'd4, 8'h00);
        rd_check(3'd4, 8'h00, "R4 line B cleared again");

        // R5 dedicated line B pin
        @(negedge clk) ext_b_n = 1'b0;
        settle();
        rd_check(3'd4, 8'h00, "R5 pin ignored with a mask clear");
        wr(3'd2, 8'hFF);
        settle();
        irq_check(2'b00, "R7 line B flag not enabled");
        rd_check(3'd4, 8'h02, "R5 pin accepted all masked");
        wr(3'd3, 8'h08);
        irq_check(2'b10, "R7 line B request");
        @(negedge clk) ext_b_n = 1'b1;
        settle();
        wr(3'd4, 8'h00);
        rd_check(3'd4, 8'h00, "R5 cleared");
        irq_check(2'b00, "R7 request dropped");

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule